// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a down-counting watchdog for a system that must prove it is still alive. Software loads a reload value. It then writes a specific feed code at regular intervals to refill the counter before it runs out. The counter steps down once for every pulse on a tick-enable input, so the count rate is set by whatever drives that input.

Every write to the block must carry a fixed 16-bit key in the upper half of the data word. A write without the key is dropped, whatever its address. This keeps a runaway program from disabling or feeding the watchdog by accident.

When the count runs out, a mode bit selects one of two responses:
- **Reset mode:** the block emits a single-cycle reset request and the counter stays at zero.
- **Interrupt mode:** the block sets a sticky interrupt flag and the counter refills itself from the reload value.

Register map:

| Address | Register | Write behaviour | Readback |
|---|---|---|---|
| 0 | control | bit 0 enable, bit 1 mode (1 = interrupt, 0 = reset), bit 2 clears the interrupt flag and is write-only | enable and mode in bits 1:0, all other bits zero |
| 1 | reload | loads the reload value | the reload value, zero-extended |
| 2 | feed | bits 15:0 carry the feed code | always zero |
| 3 | count | read only | the current count |

Top module: `guard_timer`

## Requirements
- R1: A write is accepted only when wr_data[31:16] equals 0x5AFA. A write with any other upper half changes nothing, at any address: control, reload, feed, or interrupt clear.
- R2: A keyed write to address 2 with wr_data[15:0] = 0x55AA loads the counter from the reload register. The new count appears on the clock edge that takes the write.
- R3: A keyed write to address 2 with any low half other than 0x55AA leaves the count unchanged.
- R4: While enabled (control bit 0 = 1), each cycle with tick high lowers the count by one. While disabled, ticks leave the count unchanged. A count of zero stays at zero.
- R5: In reset mode (control bit 1 = 0), a tick that takes the count from 1 to 0 raises rst_req for exactly one cycle, on the same edge that updates the count. The count then stays at zero.
- R6: In interrupt mode (control bit 1 = 1), the expiring tick sets irq, which then stays set. On the same edge the count is refilled from the reload register, and rst_req stays low.
- R7: irq clears only on a keyed write to address 0 with bit 2 set. A keyed control write with bit 2 clear leaves irq set.
- R8: After reset, the block is disabled and in reset mode. irq and rst_req are low, and both the count and the reload register hold RST_RELOAD.
- R9: rd_data shows the register chosen by rd_addr one cycle later. Address 0 returns {mode, enable} in bits 1:0 with every other bit zero, including the key field. Address 1 returns the reload value, address 2 returns zero, and address 3 returns the count.
- R10: A keyed write to the reload register does not change the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one decrement per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 reload, 2 feed |
| wr_data | input | 32 | Write data, key in bits 31:16 |
| rd_addr | input | 2 | Read address: 0 control, 1 reload, 2 feed, 3 count |
| rd_data | output | 32 | Registered readback |
| count | output | CNT_W | Current counter value |
| rst_req | output | 1 | One-cycle reset request on expiry in reset mode |
| irq | output | 1 | Sticky expiry flag in interrupt mode |

## Verification
The bench builds the block with CNT_W = 16 and RST_RELOAD = 20.

A reset value of 20 is distinct from every value the bench later writes. This makes it visible when a rejected write or a reload-register write wrongly disturbs the count.

Reload values of 5 and 2 bring expiry within a few ticks. Expiry is exercised in both modes, including the cycles just after the single reset pulse and repeated expiries while the interrupt flag is already set.

// File: rtl/gt_pkg.sv
package gt_pkg;
  localparam logic [15:0] GT_KEY  = 16'h5AFA;
  localparam logic [15:0] GT_FEED = 16'h55AA;

  typedef enum logic [1:0] {
    GT_A_CTRL   = 2'd0,
    GT_A_RELOAD = 2'd1,
    GT_A_FEED   = 2'd2,
    GT_A_COUNT  = 2'd3
  } gt_addr_e;

  localparam int GT_B_EN   = 0;
  localparam int GT_B_MODE = 1;
  localparam int GT_B_CLR  = 2;
endpackage

// File: rtl/gt_keygate.sv
module gt_keygate
  import gt_pkg::*;
(
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  output logic        ctrl_we,
  output logic        reload_we,
  output logic        feed_ok,
  output logic        irq_clr,
  output logic [15:0] wr_low
);
  logic key_ok;

  always_comb begin
    key_ok    = wr_en && (wr_data[31:16] == GT_KEY);
    wr_low    = wr_data[15:0];
    ctrl_we   = key_ok && (wr_addr == GT_A_CTRL);
    reload_we = key_ok && (wr_addr == GT_A_RELOAD);
    feed_ok   = key_ok && (wr_addr == GT_A_FEED) && (wr_data[15:0] == GT_FEED);
    irq_clr   = ctrl_we && wr_data[GT_B_CLR];
  end
endmodule

// File: rtl/gt_counter.sv
module gt_counter #(
  parameter int              CNT_W      = 16,
  parameter logic [CNT_W-1:0] RST_RELOAD = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic             irq_mode,
  input  logic             load,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_comb expire = tick && en && !load && (count == ONE);

  always_ff @(posedge clk) begin
    if (rst)                        count <= RST_RELOAD;
    else if (load)                  count <= reload_val;
    else if (expire && irq_mode)    count <= reload_val;
    else if (tick && en && count != '0) count <= count - ONE;
  end

  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(count)); // R4
  AST_FEED_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == $past(reload_val))); // R2
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import gt_pkg::*;
#(
  parameter int               CNT_W      = 16,
  parameter logic [CNT_W-1:0] RST_RELOAD = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [1:0]       rd_addr,
  output logic [31:0]      rd_data,
  output logic [CNT_W-1:0] count,
  output logic             rst_req,
  output logic             irq
);
  logic             ctrl_we, reload_we, feed_ok, irq_clr;
  logic [15:0]      wr_low;
  logic             en_q, mode_q, expire;
  logic [CNT_W-1:0] reload_q;

  gt_keygate u_gate (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_we(ctrl_we), .reload_we(reload_we), .feed_ok(feed_ok),
    .irq_clr(irq_clr), .wr_low(wr_low)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      mode_q   <= 1'b0;
      reload_q <= RST_RELOAD;
    end else begin
      if (ctrl_we) begin
        en_q   <= wr_low[GT_B_EN];
        mode_q <= wr_low[GT_B_MODE];
      end
      if (reload_we) reload_q <= wr_low[CNT_W-1:0];
    end
  end

  gt_counter #(.CNT_W(CNT_W), .RST_RELOAD(RST_RELOAD)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .en(en_q), .irq_mode(mode_q),
    .load(feed_ok), .reload_val(reload_q), .count(count), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req <= 1'b0;
      irq     <= 1'b0;
    end else begin
      rst_req <= expire && !mode_q;
      if (expire && mode_q) irq <= 1'b1;
      else if (irq_clr)     irq <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (gt_addr_e'(rd_addr))
        GT_A_CTRL:   rd_data <= {30'd0, mode_q, en_q};
        GT_A_RELOAD: rd_data <= 32'(reload_q);
        GT_A_FEED:   rd_data <= '0;
        default:     rd_data <= 32'(count);
      endcase
    end
  end

  AST_KEY_GUARD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[31:16] != GT_KEY) |=> ($stable(reload_q) && $stable(en_q) && $stable(mode_q))); // R1
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq); // R7
  AST_IRQ_NO_RST: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> !rst_req); // R6
endmodule

// File: tb/guard_timer_bench.sv
module guard_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic clk = 0, rst = 1, tick = 0, wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [CNT_W-1:0] count;
  logic rst_req, irq;
  int checks = 0, fails = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  guard_timer #(.CNT_W(CNT_W), .RST_RELOAD(16'd20)) u_guard_timer (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .count(count), .rst_req(rst_req), .irq(irq));

  // {op(1=tick), addr, data, expected count}
  localparam logic [50:0] VEC [0:11] = '{
    {1'b0, 2'd1, 32'h5AFA0005, 16'd20}, // R10 reload write keeps count
    {1'b0, 2'd2, 32'h5AFA55AA, 16'd5},  // R2 feed
    {1'b1, 2'd0, 32'h0,        16'd5},  // R4 disabled tick
    {1'b0, 2'd0, 32'h5AFA0001, 16'd5},  // R1 keyed enable
    {1'b1, 2'd0, 32'h0,        16'd4},  // R4
    {1'b1, 2'd0, 32'h0,        16'd3},  // R4
    {1'b0, 2'd2, 32'h5AFA1234, 16'd3},  // R3 wrong feed code
    {1'b0, 2'd2, 32'h12AB55AA, 16'd3},  // R1 feed without key
    {1'b0, 2'd0, 32'h00000000, 16'd3},  // R1 disable without key
    {1'b1, 2'd0, 32'h0,        16'd2},  // R1 still enabled
    {1'b0, 2'd1, 32'h00000009, 16'd2},  // R1 reload without key
    {1'b0, 2'd2, 32'h5AFA55AA, 16'd5}   // R1 reload kept at 5
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic tk();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk(32'(count), 32'd20, "R8 reset count");
    chk({31'd0, irq}, 0, "R8 reset irq");
    chk({31'd0, rst_req}, 0, "R8 reset rst_req");
    rd(2'd0, rv); chk(rv, 0, "R8 reset control");
    rd(2'd1, rv); chk(rv, 20, "R8 reset reload");

    for (int i = 0; i < 12; i++) begin
      if (VEC[i][50]) tk();
      else wr(VEC[i][49:48], VEC[i][47:16]);
      chk(32'(count), 32'(VEC[i][15:0]), $sformatf("vector %0d count", i));
    end

    rd(2'd0, rv); chk(rv, 32'h1, "R9 control readback, key zero");
    rd(2'd1, rv); chk(rv, 32'd5, "R9 reload readback");
    rd(2'd2, rv); chk(rv, 32'd0, "R9 feed readback");
    rd(2'd3, rv); chk(rv, 32'd5, "R9 count readback");

    wr(2'd1, 32'h5AFA0002);
    wr(2'd2, 32'h5AFA55AA);
    chk(32'(count), 2, "R2 feed to 2");
    tk(); chk({31'd0, rst_req}, 0, "R5 no pulse before expiry");
    tk(); chk(32'(count), 0, "R5 count at zero");
    chk({31'd0, rst_req}, 1, "R5 pulse on expiry");
    @(negedge clk); chk({31'd0, rst_req}, 0, "R5 pulse one cycle");
    tk(); chk(32'(count), 0, "R4 zero holds");
    chk({31'd0, rst_req}, 0, "R5 no second pulse");

    wr(2'd0, 32'h5AFA0003);
    wr(2'd2, 32'h5AFA55AA);
    tk(); tk();
    chk({31'd0, irq}, 1, "R6 irq on expiry");
    chk(32'(count), 2, "R6 auto reload");
    chk({31'd0, rst_req}, 0, "R6 no reset request");
    tk(); tk();
    chk({31'd0, irq}, 1, "R6 irq after second expiry");
    rd(2'd0, rv); chk(rv, 32'h3, "R9 control readback irq mode");
    wr(2'd0, 32'h00000007); chk({31'd0, irq}, 1, "R1 clear without key");
    wr(2'd0, 32'h5AFA0003); chk({31'd0, irq}, 1, "R7 keyed write without clear bit");
    wr(2'd0, 32'h5AFA0007); chk({31'd0, irq}, 0, "R7 keyed clear");
    wr(2'd0, 32'h5AFA0000);
    tk(); chk(32'(count), 2, "R4 disabled after keyed write");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule